// File: doc/BRIEF.md
# Transmit Sequence-ID Retry Controller

This block sits on the transmit side of a point-to-point packet link, between the packet source and the serializer. Each packet it takes from upstream gets a link-local sequence ID, one more than the last one and wrapping at the width limit. The packet's descriptor is written into a small indexed retry store and passed to the serializer on the next cycle. A store entry stays in use until the link partner acknowledges that ID or any later outstanding ID. Symbol encoding, CRC and the lane PHY belong to other blocks. The sequence ID is not covered by the end-to-end check, so it can be assigned again on every hop.

The partner may report that a packet was not accepted. The block then stops taking new packets and asks for one link-request/port-status control symbol. It then waits for the partner's link response, which carries the ID the next transmitted packet must use. Entries older than that ID count as delivered. Entries from that ID onward are resent from the store in their original order, and only after that does the block take new packets again. A saturating counter limits the wait. If it runs out, the link is declared dead until reset.

The controller has five states:
- RUN: normal transmission.
- REQ: one cycle that requests the status symbol.
- WAIT: waiting for the link response.
- REPLAY: resending stored packets.
- DEAD: fatal, left only by reset.

Its transitions are:
- RUN goes to REQ on a not-accepted event.
- REQ always goes to WAIT.
- WAIT goes to RUN on a valid response equal to the next new ID.
- WAIT goes to REPLAY on any other valid response.
- WAIT goes to DEAD when the wait limit expires.
- REPLAY goes to RUN after the last stored packet.
- REPLAY goes to REQ on a not-accepted event.

Top module: `lnk_ackret_ctrl`

## Requirements
- R1: After reset, `up_ready` is 1 and `tx_valid`, `req_lreq`, `proto_err` and `link_fatal` are 0. The first packet accepted gets ID 0.
- R2: A packet accepted on a clock edge (`up_valid` and `up_ready` both high) appears on `tx_valid`/`tx_id`/`tx_desc` in the following cycle with its descriptor. Each new ID is the previous one plus 1, modulo 2^ID_W.
- R3: `up_ready` is 0 whenever the number of unacknowledged packets equals 2^DEPTH_LOG2. A packet offered then is not sent.
- R4: An acknowledge for an outstanding ID n frees n and every older outstanding entry.
- R5: An acknowledge whose ID is not outstanding raises `proto_err` for one cycle, in the cycle after the event, and frees nothing.
- R6: In RUN or REPLAY, a not-accepted event drops `up_ready`. In the next cycle `req_lreq` is high for exactly one cycle, and the block then waits with no transmission.
- R7: A link response with an ID r inside the outstanding window frees every entry older than r. Starting one cycle after the response cycle, it resends IDs r up to the newest in order, one per cycle, with their stored descriptors. New packets are accepted only after the last one has been resent.
- R8: A link response whose ID equals the next new ID resends nothing and reopens `up_ready` in the next cycle.
- R9: While waiting, a link response whose ID is neither outstanding nor the next new ID raises `proto_err` for one cycle, and the block keeps waiting.
- R10: If no valid response arrives within WAIT_MAX cycles of waiting, `link_fatal` rises and stays high with `up_ready` at 0 until reset. A later response is ignored.
- R11: A link response in RUN state is ignored: nothing is sent, no error is flagged and numbering continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream offers a packet |
| up_desc | input | DESC_W | Descriptor of the offered packet |
| up_ready | output | 1 | Upstream packet is taken on this edge |
| tx_valid | output | 1 | Packet to the serializer this cycle |
| tx_id | output | ID_W | Sequence ID of the transmitted packet |
| tx_desc | output | DESC_W | Descriptor of the transmitted packet |
| ev_ack | input | 1 | Partner accepted a packet |
| ev_ack_id | input | ID_W | ID carried by the accept event |
| ev_nack | input | 1 | Partner reported a packet as not accepted |
| ev_lresp | input | 1 | Link response received |
| ev_lresp_id | input | ID_W | Next ID the partner expects |
| req_lreq | output | 1 | Request to emit a link-request/port-status symbol |
| proto_err | output | 1 | One-cycle flag for a bad acknowledge or response ID |
| link_fatal | output | 1 | Sticky flag: link response never came |

## Verification
A wrong head pointer shows in two places. Back-pressure rises at the wrong fill level (`up_ready` against the model's count, seen in the same cycle). A valid acknowledge is wrongly flagged as an error one cycle after the event. A wrong next-ID or replay pointer shows on `tx_id` one cycle after the edge, as a skipped or repeated number, or as a descriptor that does not match the stored one. A wrong state shows as a missing or doubled `req_lreq` pulse, or as `link_fatal` rising a cycle early or late relative to the wait limit.

// File: rtl/lnk_ackret_pkg.sv
package lnk_ackret_pkg;
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_REQ    = 3'd1,
        ST_WAIT   = 3'd2,
        ST_REPLAY = 3'd3,
        ST_DEAD   = 3'd4
    } ret_state_t;
endpackage

// File: rtl/lnk_ackret_store.sv
// Retry store: one descriptor per low-order sequence-ID index.
module lnk_ackret_store #(
    parameter int AW     = 3,
    parameter int DESC_W = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DESC_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [DESC_W-1:0] rd_data
);
    localparam int ENTRIES = 1 << AW;

    logic [DESC_W-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/lnk_ackret_window.sv
// Modular window test: is probe within [base, limit) or [base, limit]?
module lnk_ackret_window #(
    parameter int ID_W      = 5,
    parameter bit INCLUSIVE = 1'b0
) (
    input  logic [ID_W-1:0] base,
    input  logic [ID_W-1:0] limit,
    input  logic [ID_W-1:0] probe,
    output logic            hit
);
    logic [ID_W-1:0] off;
    logic [ID_W-1:0] span;

    assign off  = probe - base;
    assign span = limit - base;

    generate
        if (INCLUSIVE) begin : g_incl
            assign hit = (off <= span);
        end else begin : g_strict
            assign hit = (off < span);
        end
    endgenerate
endmodule

// File: rtl/lnk_ackret_timer.sv
// Saturating wait counter; expired while running at the final count.
module lnk_ackret_timer #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + CW'(1);
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/lnk_ackret_ctrl.sv
module lnk_ackret_ctrl
    import lnk_ackret_pkg::*;
#(
    parameter int ID_W       = 5,
    parameter int DEPTH_LOG2 = 3,
    parameter int DESC_W     = 16,
    parameter int WAIT_MAX   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    input  logic [DESC_W-1:0] up_desc,
    output logic              up_ready,
    output logic              tx_valid,
    output logic [ID_W-1:0]   tx_id,
    output logic [DESC_W-1:0] tx_desc,
    input  logic              ev_ack,
    input  logic [ID_W-1:0]   ev_ack_id,
    input  logic              ev_nack,
    input  logic              ev_lresp,
    input  logic [ID_W-1:0]   ev_lresp_id,
    output logic              req_lreq,
    output logic              proto_err,
    output logic              link_fatal
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam logic [ID_W-1:0] DEPTH_ID = ID_W'(DEPTH);

    ret_state_t state_q, state_d;
    logic [ID_W-1:0]   head_q, next_q, rp_q;
    logic [ID_W-1:0]   outstanding;
    logic              tx_valid_q, perr_q;
    logic [ID_W-1:0]   tx_id_q;
    logic [DESC_W-1:0] tx_desc_q;
    logic [DESC_W-1:0] rd_data;
    logic              accept, ack_hit, resp_hit, resp_ok, wait_expired, full;

    assign outstanding = next_q - head_q;
    assign full        = (outstanding == DEPTH_ID);

    lnk_ackret_store #(.AW(DEPTH_LOG2), .DESC_W(DESC_W)) store_i (
        .clk     (clk),
        .wr_en   (accept),
        .wr_idx  (next_q[DEPTH_LOG2-1:0]),
        .wr_data (up_desc),
        .rd_idx  (rp_q[DEPTH_LOG2-1:0]),
        .rd_data (rd_data)
    );

    lnk_ackret_window #(.ID_W(ID_W), .INCLUSIVE(1'b0)) ack_win_i (
        .base (head_q), .limit (next_q), .probe (ev_ack_id), .hit (ack_hit)
    );

    lnk_ackret_window #(.ID_W(ID_W), .INCLUSIVE(1'b1)) resp_win_i (
        .base (head_q), .limit (next_q), .probe (ev_lresp_id), .hit (resp_hit)
    );

    lnk_ackret_timer #(.LIMIT(WAIT_MAX)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_WAIT),
        .expired (wait_expired)
    );

    assign resp_ok = ev_lresp && resp_hit;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (ev_nack) state_d = ST_REQ;
            ST_REQ:    state_d = ST_WAIT;
            ST_WAIT: begin
                if (resp_ok)
                    state_d = (ev_lresp_id == next_q) ? ST_RUN : ST_REPLAY;
                else if (wait_expired)
                    state_d = ST_DEAD;
            end
            ST_REPLAY: begin
                if (ev_nack)                       state_d = ST_REQ;
                else if (rp_q + ID_W'(1) == next_q) state_d = ST_RUN;
            end
            ST_DEAD:   state_d = ST_DEAD;
            default:   state_d = ST_DEAD;
        endcase
    end

    // Outputs
    always_comb begin
        up_ready   = (state_q == ST_RUN) && !full;
        accept     = up_valid && up_ready;
        req_lreq   = (state_q == ST_REQ);
        link_fatal = (state_q == ST_DEAD);
        tx_valid   = tx_valid_q;
        tx_id      = tx_id_q;
        tx_desc    = tx_desc_q;
        proto_err  = perr_q;
    end

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_RUN;
            head_q     <= '0;
            next_q     <= '0;
            rp_q       <= '0;
            tx_valid_q <= 1'b0;
            tx_id_q    <= '0;
            tx_desc_q  <= '0;
            perr_q     <= 1'b0;
        end else begin
            state_q    <= state_d;
            tx_valid_q <= 1'b0;
            perr_q     <= 1'b0;

            if (accept) begin
                tx_valid_q <= 1'b1;
                tx_id_q    <= next_q;
                tx_desc_q  <= up_desc;
                next_q     <= next_q + ID_W'(1);
            end else if (state_q == ST_REPLAY) begin
                tx_valid_q <= 1'b1;
                tx_id_q    <= rp_q;
                tx_desc_q  <= rd_data;
                rp_q       <= rp_q + ID_W'(1);
            end

            if (state_q == ST_WAIT && resp_ok) begin
                head_q <= ev_lresp_id;
                rp_q   <= ev_lresp_id;
            end else if (ev_ack && state_q != ST_DEAD && ack_hit) begin
                head_q <= ev_ack_id + ID_W'(1);
            end

            if ((ev_ack && state_q != ST_DEAD && !ack_hit) ||
                (ev_lresp && state_q == ST_WAIT && !resp_hit))
                perr_q <= 1'b1;
        end
    end
endmodule

// File: rtl/lnk_ackret_chk.sv
module lnk_ackret_chk
    import lnk_ackret_pkg::*;
#(
    parameter int ID_W  = 5,
    parameter int DEPTH = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            up_ready,
    input logic            tx_valid,
    input logic [ID_W-1:0] tx_id,
    input logic            req_lreq,
    input logic            link_fatal,
    input ret_state_t      st,
    input logic [ID_W-1:0] outstanding
);
    // R3
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding == ID_W'(DEPTH)) |-> !up_ready);

    // R2
    id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(tx_valid)) |-> (tx_id == $past(tx_id) + ID_W'(1)));

    // R6
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_lreq |=> !req_lreq);

    // R6
    req_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_lreq |-> !up_ready);

    // R6
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> (!tx_valid && !up_ready));

    // R10
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_fatal |=> (link_fatal && !up_ready));
endmodule

bind lnk_ackret_ctrl lnk_ackret_chk #(.ID_W(ID_W), .DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .up_ready    (up_ready),
    .tx_valid    (tx_valid),
    .tx_id       (tx_id),
    .req_lreq    (req_lreq),
    .link_fatal  (link_fatal),
    .st          (state_q),
    .outstanding (outstanding)
);

// File: tb/lnk_ackret_ctrl_tb_top.sv
`timescale 1ns/1ps
module lnk_ackret_ctrl_tb_top;
    localparam int ID_W = 5, DL2 = 3, DW = 16, WMAX = 16;
    localparam int NID = 1 << ID_W, DEP = 1 << DL2;

    logic clk = 0, rst_n = 0;
    logic up_valid = 0, ev_ack = 0, ev_nack = 0, ev_lresp = 0;
    logic [DW-1:0] up_desc = '0;
    logic [ID_W-1:0] ev_ack_id = '0, ev_lresp_id = '0;
    logic up_ready, tx_valid, req_lreq, proto_err, link_fatal;
    logic [ID_W-1:0] tx_id;
    logic [DW-1:0] tx_desc;

    always #2.5 clk = ~clk;

    lnk_ackret_ctrl #(.ID_W(ID_W), .DEPTH_LOG2(DL2), .DESC_W(DW), .WAIT_MAX(WMAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_desc(up_desc), .up_ready(up_ready),
        .tx_valid(tx_valid), .tx_id(tx_id), .tx_desc(tx_desc), .ev_ack(ev_ack),
        .ev_ack_id(ev_ack_id), .ev_nack(ev_nack), .ev_lresp(ev_lresp),
        .ev_lresp_id(ev_lresp_id), .req_lreq(req_lreq), .proto_err(proto_err),
        .link_fatal(link_fatal));

    int nchk = 0, nfail = 0;
    int mhead = 0, mnext = 0;
    logic [DW-1:0] mdesc [NID];

    function automatic int mcount();
        return (mnext - mhead) & (NID - 1);
    endfunction
    function automatic bit outst(int id);
        return ((id - mhead) & (NID - 1)) < mcount();
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; up_valid = 0; ev_ack = 0; ev_nack = 0; ev_lresp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; mhead = 0; mnext = 0;
        @(negedge clk);
        chk(up_ready == 1, "R1", "up_ready", up_ready, 1);
        chk(tx_valid == 0 && req_lreq == 0, "R1", "tx/req", tx_valid + 2*req_lreq, 0);
        chk(proto_err == 0 && link_fatal == 0, "R1", "err/fatal", proto_err + 2*link_fatal, 0);
    endtask

    task automatic send(logic [DW-1:0] d);
        bit exp_rdy = (mcount() < DEP);
        chk(up_ready == exp_rdy, "R3", "up_ready vs fill", up_ready, exp_rdy);
        up_valid = 1; up_desc = d;
        @(negedge clk);
        up_valid = 0;
        if (exp_rdy) begin
            chk(tx_valid == 1, "R2", "tx_valid", tx_valid, 1);
            chk(tx_id == mnext[ID_W-1:0], "R2", "tx_id", tx_id, mnext);
            chk(tx_desc == d, "R2", "tx_desc", tx_desc, d);
            mdesc[mnext] = d; mnext = (mnext + 1) & (NID - 1);
        end else begin
            chk(tx_valid == 0, "R3", "tx while full", tx_valid, 0);
        end
    endtask

    task automatic ack(int id);
        bit hit = outst(id);
        ev_ack = 1; ev_ack_id = id[ID_W-1:0];
        @(negedge clk);
        ev_ack = 0;
        if (hit) begin
            chk(proto_err == 0, "R4", "err on valid ack", proto_err, 0);
            mhead = (id + 1) & (NID - 1);
        end else begin
            chk(proto_err == 1, "R5", "err on bogus ack", proto_err, 1);
        end
        chk(up_ready == (mcount() < DEP), "R4", "ready after ack", up_ready, mcount() < DEP);
    endtask

    task automatic nack();
        ev_nack = 1;
        @(negedge clk);
        ev_nack = 0;
        chk(req_lreq == 1 && up_ready == 0, "R6", "request cycle", req_lreq + 2*up_ready, 1);
        @(negedge clk);
        chk(req_lreq == 0 && up_ready == 0 && tx_valid == 0, "R6", "waiting",
            req_lreq + 2*up_ready + 4*tx_valid, 0);
    endtask

    task automatic resp(int id);
        bit ok = ((id - mhead) & (NID - 1)) <= mcount();
        ev_lresp = 1; ev_lresp_id = id[ID_W-1:0];
        @(negedge clk);
        ev_lresp = 0;
        if (!ok) begin
            chk(proto_err == 1 && up_ready == 0, "R9", "bad response", proto_err + 2*up_ready, 1);
            return;
        end
        chk(proto_err == 0, "R7", "no err on good response", proto_err, 0);
        mhead = id;
        if (id == mnext) begin
            chk(up_ready == 1 && tx_valid == 0, "R8", "direct resume", up_ready + 2*tx_valid, 1);
        end else begin
            for (int k = id; k != mnext; k = (k + 1) & (NID - 1)) begin
                @(negedge clk);
                chk(tx_valid == 1 && tx_id == k[ID_W-1:0], "R7", "replay id", tx_id, k);
                chk(tx_desc == mdesc[k], "R7", "replay desc", tx_desc, mdesc[k]);
            end
            chk(up_ready == (mcount() < DEP), "R7", "resume after replay", up_ready, mcount() < DEP);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        nfail++; nchk++;
        $display("FAIL watchdog act=hung exp=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        do_reset();
        // R3 fill to capacity, then one refused offer
        for (int i = 0; i < DEP + 1; i++) send(16'hA000 + 16'(i));
        // R4 cumulative acknowledge frees everything
        ack((mnext - 1) & (NID - 1));
        chk(mcount() == 0 && up_ready == 1, "R4", "all freed", up_ready, 1);
        // R5 bogus ack of an already-freed id
        ack((mhead - 1) & (NID - 1));
        // R11 unsolicited response in RUN
        send(16'h1111);
        ev_lresp = 1; ev_lresp_id = mhead[ID_W-1:0];
        @(negedge clk);
        ev_lresp = 0;
        chk(tx_valid == 0 && proto_err == 0 && up_ready == 1, "R11", "ignored",
            tx_valid + 2*proto_err + 4*up_ready, 4);
        send(16'h2222);
        // R7, R9 recovery with a bad then a good response
        send(16'h3333); send(16'h4444);
        nack();
        resp((mnext + 3) & (NID - 1));
        resp((mhead + 1) & (NID - 1));
        // R8 response equal to next id
        nack();
        resp(mnext);
        // random phase, IDs wrap several times (R2)
        for (int it = 0; it < 500; it++) begin
            int r = $urandom_range(0, 11);
            if (r <= 6) send(16'($urandom));
            else if (r <= 8) begin
                if (mcount() > 0) ack((mhead + $urandom_range(0, mcount() - 1)) & (NID - 1));
            end else if (r == 9) begin
                ack((mnext + $urandom_range(0, NID - 1 - mcount())) & (NID - 1));
            end else begin
                nack();
                if (r == 11) resp((mnext + 1 + $urandom_range(0, NID - 2 - mcount())) & (NID - 1));
                resp((mhead + $urandom_range(0, mcount())) & (NID - 1));
            end
        end
        // R10 wait limit
        send(16'h5555);
        nack();
        for (int i = 1; i < WMAX; i++) begin
            @(negedge clk);
            chk(link_fatal == 0, "R10", "early fatal", link_fatal, 0);
        end
        @(negedge clk);
        chk(link_fatal == 1, "R10", "fatal at limit", link_fatal, 1);
        ev_lresp = 1; ev_lresp_id = mhead[ID_W-1:0];
        @(negedge clk);
        ev_lresp = 0;
        repeat (2) @(negedge clk);
        chk(link_fatal == 1 && up_ready == 0 && tx_valid == 0, "R10", "stays dead",
            link_fatal + 2*up_ready + 4*tx_valid, 1);
        do_reset();
        send(16'h7777);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule